// File: doc/BRIEF.md
# MAC Address Learning and Forwarding Engine

This block holds the station table of a small multi-port Ethernet switch and turns each received-frame descriptor into a forwarding verdict. A descriptor carries the ingress port, the destination and source MAC addresses, three error flags (CRC, alignment, illegal size), a length-valid flag and a PAUSE flag. One clock later the block returns either a mask of egress ports or a drop verdict. In the same cycle, it learns or refreshes the source station in a table indexed by a hash of the MAC.

A free-running coarse timestamp stamps every entry. A scanner walks the table one slot per clock and removes entries whose age has reached the period picked by a 2-bit selector. One selector value switches removal off. A two-register control interface holds the per-port learning-disable mask and the aging selector.

Top module: `mac_fwd_engine`

## Requirements
- R1: The verdict for a descriptor presented with `in_valid` high appears on `out_valid`/`out_mask`/`out_drop` exactly one clock later. `out_valid` is low in every cycle that does not follow an accepted descriptor.
- R2: A frame is accepted for learning only when all three `in_err` bits are 0, `in_len_ok` is 1, `in_pause` is 0 and the source MAC is unicast (bit 40, the group bit of the first octet, is 0). Such a frame whose source is absent from the table writes {source MAC, ingress port, current stamp} into its slot. Any other frame leaves the table untouched.
- R3: Control register 0 (`cfg_addr`=0) bit n disables learning from port n. A frame from that port then never creates an entry.
- R4: The slot index is the XOR of the 48-bit MAC cut into index-width slices starting at bit 0, with the last slice zero-padded. Lookups compare the full 48 bits. Learning a new MAC into an occupied slot replaces the old station.
- R5: Control register 1 (`cfg_addr`=1) bits [1:0] select the aging limit: 0 disables aging, and 1, 2 and 3 select limits `LIM1`, `LIM2` and `LIM3` in stamp units. An entry whose age reaches the limit is removed when the scanner next visits its slot.
- R6: A destination with the group bit set (broadcast or multicast) goes to every port except the ingress port.
- R7: A unicast destination found in the table goes only to its learned port. A unicast destination that is not found is flooded to every port except the ingress port.
- R8: A unicast destination learned on the ingress port itself is filtered: `out_drop`=1 and `out_mask`=0.
- R9: A frame with any error flag set, with `in_len_ok`=0 or with `in_pause`=1 is dropped: `out_drop`=1 and `out_mask`=0.
- R10: After reset, register 0 reads 0 and register 1 reads `AGE_SEL_RST` (2 by default). Writes take effect on the next clock, and `cfg_rdata` returns the addressed register zero-extended.
- R11: An accepted frame whose source is already in the table rewrites that entry's stamp with the current stamp and keeps its MAC and port, so a station that keeps sending is never aged out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Descriptor present this cycle |
| in_port | input | PORT_W | Ingress port number |
| in_da | input | 48 | Destination MAC |
| in_sa | input | 48 | Source MAC |
| in_err | input | 3 | Error flags: [0] CRC, [1] alignment, [2] illegal size |
| in_len_ok | input | 1 | Frame length is legal |
| in_pause | input | 1 | Frame is a PAUSE control frame |
| out_valid | output | 1 | Verdict valid |
| out_mask | output | NUM_PORTS | Egress port mask |
| out_drop | output | 1 | Frame is discarded |
| cfg_we | input | 1 | Control register write strobe |
| cfg_addr | input | 1 | Control register select |
| cfg_wdata | input | 8 | Control write data |
| cfg_rdata | output | 8 | Addressed control register, zero-extended |

## Verification
Every verdict is due one clock after its descriptor. The bench drives each descriptor on a falling edge and reads the outputs on the next falling edge, half a cycle after the registering edge. It also confirms that `out_valid` is still low just after the drive and low again one cycle later. A table write lands on the same edge that registers the verdict, so a probe sent on the next cycle already sees the learned station. Control writes act on the next edge.

Aging results depend on the stamp divider, the table depth and the chosen limit. In the worst case, removal happens limit × divider + divider + depth cycles after the last refresh. The bench waits well beyond that bound before probing for an expired station, and keeps the refresh interval well inside the limit before probing for a live one.

// File: rtl/mac_fwd_pkg.sv
// Shared types and the slot hash for the MAC forwarding engine.
// Assumes the index width is between 1 and 16 bits.
package mac_fwd_pkg;
    localparam int MAC_W     = 48;
    localparam int GROUP_BIT = 40;

    typedef logic [MAC_W-1:0] mac_t;

    // Fold a MAC into an index: XOR of idx_w-bit slices taken from bit 0 upward.
    function automatic logic [15:0] mac_hash(input mac_t mac, input int idx_w);
        logic [15:0] h;
        h = '0;
        for (int i = 0; i < MAC_W; i++) begin
            h[4'(i % idx_w)] = h[4'(i % idx_w)] ^ mac[i];
        end
        return h;
    endfunction
endpackage

// File: rtl/mac_fwd_cfg.sv
// Control registers: per-port learning-disable mask (register 0) and
// aging selector (register 1). Assumes NUM_PORTS is at most CFG_W.
module mac_fwd_cfg #(
    parameter int         NUM_PORTS   = 4,
    parameter int         CFG_W       = 8,
    parameter logic [1:0] AGE_SEL_RST = 2'd2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic                 cfg_addr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    output logic [NUM_PORTS-1:0] learn_off,
    output logic [1:0]           age_sel
);
    logic unused_wdata_hi;

    assign unused_wdata_hi = ^cfg_wdata[CFG_W-1:NUM_PORTS];

    // Register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            learn_off <= '0;
            age_sel   <= AGE_SEL_RST;
        end else if (cfg_we) begin
            if (cfg_addr == 1'b0) learn_off <= cfg_wdata[NUM_PORTS-1:0];
            else                  age_sel   <= cfg_wdata[1:0];
        end
    end

    // Read mux, zero-extended.
    always_comb begin
        if (cfg_addr == 1'b0) cfg_rdata = CFG_W'(learn_off);
        else                  cfg_rdata = CFG_W'(age_sel);
    end

    AST_CFG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(age_sel) && $stable(learn_off))); // R10
endmodule

// File: rtl/mac_fwd_age.sv
// Aging scanner: coarse stamp counter plus a slot pointer that advances
// one slot per clock. It flags the visited slot for removal when its age
// reaches the selected limit. Assumes DEPTH is a power of two and
// STAMP_DIV >= 2.
module mac_fwd_age #(
    parameter int DEPTH     = 1024,
    parameter int TS_W      = 8,
    parameter int STAMP_DIV = 50000,
    parameter int LIM1      = 30,
    parameter int LIM2      = 75,
    parameter int LIM3      = 150,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int DIV_W    = $clog2(STAMP_DIV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       age_sel,
    input  logic             scan_valid,
    input  logic [TS_W-1:0]  scan_ts,
    output logic [IDX_W-1:0] scan_idx,
    output logic [TS_W-1:0]  stamp_now,
    output logic             age_kill
);
    logic [DIV_W-1:0] div_cnt;
    logic [TS_W-1:0]  limit;
    logic [TS_W-1:0]  age;

    // Stamp divider: stamp advances once per STAMP_DIV clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt   <= '0;
            stamp_now <= '0;
        end else if (div_cnt == DIV_W'(STAMP_DIV - 1)) begin
            div_cnt   <= '0;
            stamp_now <= stamp_now + TS_W'(1);
        end else begin
            div_cnt   <= div_cnt + DIV_W'(1);
        end
    end

    // Scan pointer walks every slot in turn.
    always_ff @(posedge clk) begin
        if (!rst_n) scan_idx <= '0;
        else        scan_idx <= scan_idx + IDX_W'(1);
    end

    // Limit lookup from the selector.
    always_comb begin
        case (age_sel)
            2'd1:    limit = TS_W'(LIM1);
            2'd2:    limit = TS_W'(LIM2);
            2'd3:    limit = TS_W'(LIM3);
            default: limit = '1;
        endcase
    end

    // Staleness test on the visited slot.
    assign age      = stamp_now - scan_ts;
    assign age_kill = (age_sel != 2'd0) && scan_valid && (age >= limit);

    AST_AGING_OFF_NO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        (age_sel == 2'd0) |-> !age_kill); // R5
    AST_STAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(stamp_now) |-> (stamp_now == $past(stamp_now) + TS_W'(1))); // R5
endmodule

// File: rtl/mac_fwd_table.sv
// Station table: valid bit, MAC, port and stamp per slot, with two
// combinational lookup ports (destination, source) and one scan port.
// A learn or refresh write wins over a removal of the same slot.
module mac_fwd_table
    import mac_fwd_pkg::*;
#(
    parameter int DEPTH  = 1024,
    parameter int PORT_W = 2,
    parameter int TS_W   = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  da_idx,
    input  logic [IDX_W-1:0]  sa_idx,
    input  logic [IDX_W-1:0]  scan_idx,
    input  logic              wr_en,
    input  logic              wr_new,
    input  logic [IDX_W-1:0]  wr_idx,
    input  mac_t              wr_mac,
    input  logic [PORT_W-1:0] wr_port,
    input  logic [TS_W-1:0]   wr_ts,
    input  logic              kill,
    output logic              da_valid,
    output mac_t              da_mac,
    output logic [PORT_W-1:0] da_port,
    output logic              sa_valid,
    output mac_t              sa_mac,
    output logic              scan_valid,
    output logic [TS_W-1:0]   scan_ts
);
    logic [DEPTH-1:0]  valid_q;
    mac_t              mac_q  [DEPTH];
    logic [PORT_W-1:0] port_q [DEPTH];
    logic [TS_W-1:0]   ts_q   [DEPTH];

    // Valid bits: removal first, write overrides it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (kill) valid_q[scan_idx] <= 1'b0;
            if (wr_en) valid_q[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: stamp on every write, MAC and port on new entries.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            ts_q[wr_idx] <= wr_ts;
            if (wr_new) begin
                mac_q[wr_idx]  <= wr_mac;
                port_q[wr_idx] <= wr_port;
            end
        end
    end

    // Read ports.
    assign da_valid   = valid_q[da_idx];
    assign da_mac     = mac_q[da_idx];
    assign da_port    = port_q[da_idx];
    assign sa_valid   = valid_q[sa_idx];
    assign sa_mac     = mac_q[sa_idx];
    assign scan_valid = valid_q[scan_idx];
    assign scan_ts    = ts_q[scan_idx];

    AST_LEARN_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_new) |=> (valid_q[$past(wr_idx)] && (mac_q[$past(wr_idx)] == $past(wr_mac)))); // R2
    AST_REFRESH_KEEPS_MAC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_new) |=> ((mac_q[$past(wr_idx)] == $past(mac_q[wr_idx]))
                                && (ts_q[$past(wr_idx)] == $past(wr_ts)))); // R11
endmodule

// File: rtl/mac_fwd_decide.sv
// Forwarding verdict: classifies the descriptor against the destination
// lookup and registers mask and drop flag one clock later.
module mac_fwd_decide #(
    parameter int NUM_PORTS = 4,
    parameter int PORT_W    = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [PORT_W-1:0]    in_port,
    input  logic                 bad_frame,
    input  logic                 da_group,
    input  logic                 da_known,
    input  logic [PORT_W-1:0]    da_port,
    output logic                 out_valid,
    output logic [NUM_PORTS-1:0] out_mask,
    output logic                 out_drop
);
    typedef enum logic [2:0] {
        V_BAD,
        V_GROUP,
        V_UNKNOWN,
        V_SAME_PORT,
        V_UNICAST
    } verdict_e;

    verdict_e             verdict;
    logic [NUM_PORTS-1:0] ingress_bit;
    logic [NUM_PORTS-1:0] dest_bit;
    logic [NUM_PORTS-1:0] next_mask;
    logic [NUM_PORTS-1:0] ingress_q;

    // Classify the frame and form its mask.
    always_comb begin
        ingress_bit          = '0;
        ingress_bit[in_port] = 1'b1;
        dest_bit             = '0;
        dest_bit[da_port]    = 1'b1;
        if (bad_frame)                verdict = V_BAD;
        else if (da_group)            verdict = V_GROUP;
        else if (!da_known)           verdict = V_UNKNOWN;
        else if (da_port == in_port)  verdict = V_SAME_PORT;
        else                          verdict = V_UNICAST;
        case (verdict)
            V_GROUP, V_UNKNOWN: next_mask = ~ingress_bit;
            V_UNICAST:          next_mask = dest_bit;
            default:            next_mask = '0;
        endcase
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
            out_drop  <= 1'b0;
            ingress_q <= '0;
        end else begin
            out_valid <= in_valid;
            out_mask  <= in_valid ? next_mask : '0;
            out_drop  <= in_valid && (verdict inside {V_BAD, V_SAME_PORT});
            ingress_q <= ingress_bit;
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_NO_INGRESS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_mask & ingress_q) == '0)); // R6
    AST_UNICAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bad_frame && !da_group && da_known && (da_port != in_port))
        |=> (($countones(out_mask) == 1) && !out_drop)); // R7
    AST_SAME_PORT_FILTER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !bad_frame && !da_group && da_known && (da_port == in_port))
        |=> (out_drop && (out_mask == '0))); // R8
    AST_BAD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad_frame) |=> (out_valid && out_drop && (out_mask == '0))); // R9
endmodule

// File: rtl/mac_fwd_engine.sv
// Top of the MAC learning and forwarding engine. It hashes both
// addresses, looks them up, decides learn/refresh and feeds the verdict
// stage. Assumes DEPTH is a power of two up to 65536 and NUM_PORTS <= 8.
module mac_fwd_engine
    import mac_fwd_pkg::*;
#(
    parameter int         NUM_PORTS   = 4,
    parameter int         DEPTH       = 1024,
    parameter int         TS_W        = 8,
    parameter int         STAMP_DIV   = 50000,
    parameter int         LIM1        = 30,
    parameter int         LIM2        = 75,
    parameter int         LIM3        = 150,
    parameter logic [1:0] AGE_SEL_RST = 2'd2,
    localparam int        PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [PORT_W-1:0]    in_port,
    input  logic [47:0]          in_da,
    input  logic [47:0]          in_sa,
    input  logic [2:0]           in_err,
    input  logic                 in_len_ok,
    input  logic                 in_pause,
    output logic                 out_valid,
    output logic [NUM_PORTS-1:0] out_mask,
    output logic                 out_drop,
    input  logic                 cfg_we,
    input  logic                 cfg_addr,
    input  logic [7:0]           cfg_wdata,
    output logic [7:0]           cfg_rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0]     da_idx, sa_idx, scan_idx;
    logic                 da_slot_valid, sa_slot_valid, scan_valid, age_kill;
    mac_t                 da_slot_mac, sa_slot_mac;
    logic [PORT_W-1:0]    da_slot_port;
    logic [TS_W-1:0]      scan_ts, stamp_now;
    logic [NUM_PORTS-1:0] learn_off;
    logic [1:0]           age_sel;
    logic                 bad_frame, frame_ok, da_known, sa_known;
    logic                 refresh, learn_new, wr_en;

    // Hashing, lookup outcome and learn/refresh decision.
    always_comb begin
        da_idx    = IDX_W'(mac_hash(in_da, IDX_W));
        sa_idx    = IDX_W'(mac_hash(in_sa, IDX_W));
        bad_frame = (|in_err) || !in_len_ok || in_pause;
        frame_ok  = in_valid && !bad_frame;
        da_known  = da_slot_valid && (da_slot_mac == in_da);
        sa_known  = sa_slot_valid && (sa_slot_mac == in_sa);
        refresh   = frame_ok && sa_known;
        learn_new = frame_ok && !sa_known && !in_sa[GROUP_BIT] && !learn_off[in_port];
        wr_en     = refresh || learn_new;
    end

    mac_fwd_cfg #(
        .NUM_PORTS  (NUM_PORTS),
        .CFG_W      (8),
        .AGE_SEL_RST(AGE_SEL_RST)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_addr (cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .learn_off(learn_off),
        .age_sel  (age_sel)
    );

    mac_fwd_age #(
        .DEPTH    (DEPTH),
        .TS_W     (TS_W),
        .STAMP_DIV(STAMP_DIV),
        .LIM1     (LIM1),
        .LIM2     (LIM2),
        .LIM3     (LIM3)
    ) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .age_sel   (age_sel),
        .scan_valid(scan_valid),
        .scan_ts   (scan_ts),
        .scan_idx  (scan_idx),
        .stamp_now (stamp_now),
        .age_kill  (age_kill)
    );

    mac_fwd_table #(
        .DEPTH (DEPTH),
        .PORT_W(PORT_W),
        .TS_W  (TS_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .da_idx    (da_idx),
        .sa_idx    (sa_idx),
        .scan_idx  (scan_idx),
        .wr_en     (wr_en),
        .wr_new    (learn_new),
        .wr_idx    (sa_idx),
        .wr_mac    (in_sa),
        .wr_port   (in_port),
        .wr_ts     (stamp_now),
        .kill      (age_kill),
        .da_valid  (da_slot_valid),
        .da_mac    (da_slot_mac),
        .da_port   (da_slot_port),
        .sa_valid  (sa_slot_valid),
        .sa_mac    (sa_slot_mac),
        .scan_valid(scan_valid),
        .scan_ts   (scan_ts)
    );

    mac_fwd_decide #(
        .NUM_PORTS(NUM_PORTS),
        .PORT_W   (PORT_W)
    ) u_decide (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_port  (in_port),
        .bad_frame(bad_frame),
        .da_group (in_da[GROUP_BIT]),
        .da_known (da_known),
        .da_port  (da_slot_port),
        .out_valid(out_valid),
        .out_mask (out_mask),
        .out_drop (out_drop)
    );

    AST_LEARN_OFF_NO_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && learn_off[in_port]) |-> !(wr_en && !sa_known)); // R3
    AST_BAD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bad_frame) |-> !wr_en); // R2
endmodule

// File: tb/mac_fwd_engine_test.sv
module mac_fwd_engine_test;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] MCAST = 48'h0100_5E00_0001;
    localparam logic [47:0] PROBE = 48'h0200_0000_003F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_port = '0;
    logic [47:0] in_da = '0;
    logic [47:0] in_sa = '0;
    logic [2:0]  in_err = '0;
    logic        in_len_ok = 1'b1;
    logic        in_pause = 1'b0;
    logic        out_valid;
    logic [3:0]  out_mask;
    logic        out_drop;
    logic        cfg_we = 1'b0;
    logic        cfg_addr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;

    int   n_checks = 0;
    int   n_fail = 0;
    logic got_valid, got_drop;
    logic [3:0] got_mask;

    always #10 clk = ~clk;

    mac_fwd_engine #(
        .NUM_PORTS(4), .DEPTH(64), .TS_W(8), .STAMP_DIV(4),
        .LIM1(3), .LIM2(8), .LIM3(30), .AGE_SEL_RST(2'd2)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_port(in_port),
        .in_da(in_da), .in_sa(in_sa), .in_err(in_err), .in_len_ok(in_len_ok),
        .in_pause(in_pause), .out_valid(out_valid), .out_mask(out_mask),
        .out_drop(out_drop), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    function automatic logic [47:0] mac(input logic [7:0] n);
        return 48'h0200_0000_0000 | 48'(n);
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input int port, input logic [47:0] da, input logic [47:0] sa,
                        input logic [2:0] err, input logic len_ok, input logic pause);
        @(negedge clk);
        in_valid = 1'b1; in_port = 2'(port); in_da = da; in_sa = sa;
        in_err = err; in_len_ok = len_ok; in_pause = pause;
        @(negedge clk);
        in_valid = 1'b0; in_err = '0; in_len_ok = 1'b1; in_pause = 1'b0;
        got_valid = out_valid; got_mask = out_mask; got_drop = out_drop;
    endtask

    task automatic expect_fwd(input string req, input int port, input logic [47:0] da,
                              input logic [47:0] sa, input logic [3:0] mask, input logic drop);
        send(port, da, sa, 3'b000, 1'b1, 1'b0);
        check(req, "valid", 32'(got_valid), 32'd1);
        check(req, "mask", 32'(got_mask), 32'(mask));
        check(req, "drop", 32'(got_drop), 32'(drop));
    endtask

    task automatic cfg_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_check(input string req, input logic a, input logic [7:0] exp);
        cfg_addr = a;
        #1;
        check(req, "cfg_rdata", 32'(cfg_rdata), 32'(exp));
    endtask

    task automatic t_reset();
        check("R1", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R1", "out_mask after reset", 32'(out_mask), 32'd0);
        cfg_check("R10", 1'b0, 8'h00);
        cfg_check("R10", 1'b1, 8'h02);
    endtask

    task automatic t_latency();
        @(negedge clk);
        in_valid = 1'b1; in_port = 2'd1; in_da = BCAST; in_sa = mac(8'h01);
        #1;
        check("R1", "out_valid before edge", 32'(out_valid), 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R1", "out_valid one cycle later", 32'(out_valid), 32'd1);
        check("R1", "mask one cycle later", 32'(out_mask), 32'hD);
        @(negedge clk);
        check("R1", "out_valid drops", 32'(out_valid), 32'd0);
    endtask

    task automatic t_group();
        expect_fwd("R6", 2, BCAST, mac(8'h02), 4'b1011, 1'b0);
        expect_fwd("R6", 0, MCAST, mac(8'h03), 4'b1110, 1'b0);
    endtask

    task automatic t_unicast();
        expect_fwd("R6", 1, BCAST, mac(8'h0A), 4'b1101, 1'b0);
        expect_fwd("R7 known", 0, mac(8'h0A), PROBE, 4'b0010, 1'b0);
        expect_fwd("R7 unknown", 3, mac(8'h2F), mac(8'h04), 4'b0111, 1'b0);
        expect_fwd("R8", 1, mac(8'h0A), mac(8'h05), 4'b0000, 1'b1);
    endtask

    task automatic t_bad();
        for (int k = 0; k < 5; k++) begin
            logic [2:0] e;
            logic lok, pz;
            e = (k < 3) ? 3'(1 << k) : 3'b000;
            lok = (k != 3);
            pz = (k == 4);
            send(2, mac(8'h0A), mac(8'h0B), e, lok, pz);
            check("R9", "valid", 32'(got_valid), 32'd1);
            check("R9", "drop", 32'(got_drop), 32'd1);
            check("R9", "mask", 32'(got_mask), 32'd0);
        end
        expect_fwd("R2 bad not learned", 0, mac(8'h0B), PROBE, 4'b1110, 1'b0);
        expect_fwd("R2", 1, BCAST, mac(8'h1E), 4'b1101, 1'b0);
        expect_fwd("R2", 2, BCAST, 48'h0300_0000_000E, 4'b1011, 1'b0);
        expect_fwd("R2 group SA not learned", 0, mac(8'h1E), PROBE, 4'b0010, 1'b0);
    endtask

    task automatic t_learn_off();
        cfg_write(1'b0, 8'h08);
        cfg_check("R10", 1'b0, 8'h08);
        expect_fwd("R3", 3, BCAST, mac(8'h0C), 4'b0111, 1'b0);
        expect_fwd("R3 disabled port not learned", 0, mac(8'h0C), PROBE, 4'b1110, 1'b0);
        cfg_write(1'b0, 8'h00);
        expect_fwd("R3", 3, BCAST, mac(8'h0C), 4'b0111, 1'b0);
        expect_fwd("R3 enabled port learned", 0, mac(8'h0C), PROBE, 4'b1000, 1'b0);
    endtask

    task automatic t_collision();
        expect_fwd("R4", 2, BCAST, mac(8'h10), 4'b1011, 1'b0);
        expect_fwd("R4 first station", 0, mac(8'h10), PROBE, 4'b0100, 1'b0);
        expect_fwd("R4", 3, BCAST, 48'h0200_0000_00D3, 4'b0111, 1'b0);
        expect_fwd("R4 evicted", 0, mac(8'h10), PROBE, 4'b1110, 1'b0);
        expect_fwd("R4 new station", 0, 48'h0200_0000_00D3, PROBE, 4'b1000, 1'b0);
    endtask

    task automatic t_aging();
        cfg_write(1'b1, 8'h01);
        cfg_check("R10", 1'b1, 8'h01);
        expect_fwd("R5", 2, BCAST, mac(8'h20), 4'b1011, 1'b0);
        idle(120);
        expect_fwd("R5 expired", 0, mac(8'h20), PROBE, 4'b1110, 1'b0);
    endtask

    task automatic t_refresh();
        cfg_write(1'b1, 8'h02);
        expect_fwd("R11", 2, BCAST, mac(8'h21), 4'b1011, 1'b0);
        expect_fwd("R11", 1, BCAST, mac(8'h22), 4'b1101, 1'b0);
        for (int i = 0; i < 15; i++) begin
            idle(10);
            send(2, BCAST, mac(8'h21), 3'b000, 1'b1, 1'b0);
        end
        expect_fwd("R11 refreshed kept", 0, mac(8'h21), PROBE, 4'b0100, 1'b0);
        expect_fwd("R5 idle station expired", 0, mac(8'h22), PROBE, 4'b1110, 1'b0);
    endtask

    task automatic t_aging_off();
        cfg_write(1'b1, 8'h00);
        expect_fwd("R5", 3, BCAST, mac(8'h23), 4'b0111, 1'b0);
        idle(300);
        expect_fwd("R5 aging disabled", 0, mac(8'h23), PROBE, 4'b1000, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_group();
        t_unicast();
        t_bad();
        t_learn_off();
        t_collision();
        t_aging();
        t_refresh();
        t_aging_off();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule